// File: doc/BRIEF.md
# Processor Burst Bus Bridge

This block links a simple processor-side port, whose data width is fixed at 8, 16 or 32 bits by a parameter, to a 32-bit internal system bus that carries one parity bit for each byte. A request/acknowledge handshake on the processor side carries two kinds of transfer. A single transfer moves one port beat to or from one word. A burst always moves one 16-byte line, so it needs 4, 8 or 16 beats depending on the port width.

On writes, narrow beats are collected into 32-bit words. The first beat fills the lowest byte lanes. Each finished word is queued and then issued as one system-bus write. On reads, the bridge fetches the words of the line into a read queue and hands them out in the same lane order. The two queues let the processor side and the system side run at uneven rates.

Byte parity is always generated on both sides. When checking is enabled, a write beat whose parity does not match is dropped, and any parity mismatch on either side sets a sticky error flag.

Top module: `proc_burst_bridge`

## Requirements
- R1: A burst completes after exactly 16/(PORT_W/8) acknowledged beats, and a single transfer completes after one acknowledged beat.
- R2: Burst write beats are packed little-endian: beat k fills byte lanes starting at (k*PORT_W/8) mod 4. Each completed word produces one system write with byte enables 4'b1111, at the burst base address plus 4 per word in increasing order.
- R3: A single write produces one system write to the word containing the address. Its byte enables cover PORT_W/8 lanes starting at the address's low two bits rounded down to the port width, and the beat's data sits in those lanes.
- R4: A burst read fetches the four words from the base address upward and returns them lowest lanes first. A single read returns the lanes selected by the same offset rule as R3.
- R5: A burst whose address has a nonzero value in bits [3:0] is rejected. The error output pulses high for exactly one cycle, no beat is acknowledged and no system transaction is issued.
- R6: Parity is even per byte: the parity bit of each lane equals the XOR of that lane's eight data bits. This holds for the system write parity and for the processor read parity.
- R7: With parity checking enabled, a write beat whose parity bits mismatch its data sets the error flag and its lanes are left out of the byte enables. A word left with no enabled lane issues no system write. With checking disabled, parity bits are ignored and the beat is written.
- R8: With checking enabled, system read parity that mismatches the read data sets the error flag, and the data is still delivered. With checking disabled, read parity is ignored.
- R9: The parity error flag stays set until reset.
- R10: The processor acknowledge stays low while the write queue is full (writes) or the read queue is empty (reads). A system request holds its address, direction, enables and data unchanged until it is acknowledged. Neither queue is ever pushed while full.
- R11: Writes queued by earlier transfers complete on the system bus before a later read fetches any word.
- R12: A synchronous active-high reset empties both queues, clears the error flag and returns the control to idle. In the cycle after reset, acknowledge, error pulse and system request are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| par_en | input | 1 | Enables parity checking |
| p_req | input | 1 | Processor transfer request, held for the whole transfer |
| p_wr | input | 1 | 1 = write, 0 = read |
| p_burst | input | 1 | 1 = 16-byte burst, 0 = single beat |
| p_addr | input | 32 | Byte address of the transfer |
| p_wdata | input | PORT_W | Write beat data |
| p_wpar | input | PORT_W/8 | Even parity of the write beat, one bit per byte |
| p_ack | output | 1 | Beat accepted or read data valid this cycle |
| p_err | output | 1 | One-cycle pulse rejecting an unaligned burst |
| p_rdata | output | PORT_W | Read beat data |
| p_rpar | output | PORT_W/8 | Even parity of the read beat |
| par_err | output | 1 | Sticky parity error flag |
| s_req | output | 1 | System-bus request |
| s_we | output | 1 | System-bus write enable |
| s_addr | output | 32 | System-bus word address (bits [1:0] zero) |
| s_be | output | 4 | System-bus byte enables |
| s_wdata | output | 32 | System-bus write data |
| s_wpar | output | 4 | System-bus write parity |
| s_ack | input | 1 | System-bus acknowledge |
| s_rdata | input | 32 | System-bus read data, valid with s_ack |
| s_rpar | input | 4 | System-bus read parity |

## Verification
Several rules are checked by assertions on every cycle. These are the quiet state after reset, the stickiness of the error flag, the one-cycle reject pulse and its unaligned-burst cause, the stable system request until acknowledge, the absence of pushes into full queues, and nonzero enables on every system write. Only the bench scenarios can show the rest. That covers the lane order of packing and unpacking, the addresses of the four line words, the dropping of a bad-parity beat, the ignored parity when checking is off, and that a read issued right after slow writes returns the freshly written data.

// File: rtl/pbb_pkg.sv
package pbb_pkg;

   localparam int SYS_W      = 32;
   localparam int SYS_LANES  = SYS_W / 8;
   localparam int LINE_BYTES = 16;
   localparam int LINE_WORDS = LINE_BYTES / SYS_LANES;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_XFER,
      ST_REJECT
   } pbb_state_e;

   // one queued system-bus write
   typedef struct packed {
      logic [29:0]          waddr;
      logic [SYS_LANES-1:0] be;
      logic [SYS_W-1:0]     data;
   } wr_word_t;

   function automatic logic [SYS_LANES-1:0] lane_parity(input logic [SYS_W-1:0] d);
      logic [SYS_LANES-1:0] p;
      for (int i = 0; i < SYS_LANES; i++) p[i] = ^d[8*i +: 8];
      return p;
   endfunction

endpackage

// File: rtl/pbb_fifo.sv
module pbb_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp;
   logic [AW:0]      cnt;
   logic             do_push, do_pop;

   assign full    = (cnt == (AW+1)'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (rst) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         if (do_push && !do_pop)      cnt <= cnt + 1'b1;
         else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

endmodule

// File: rtl/pbb_wpack.sv
module pbb_wpack
   import pbb_pkg::*;
#(
   parameter int PORT_W = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                par_en,
   input  logic                load,
   input  logic [1:0]          load_ptr,
   input  logic [29:0]         load_waddr,
   input  logic                single,
   input  logic                beat,
   input  logic [PORT_W-1:0]   beat_data,
   input  logic [PORT_W/8-1:0] beat_par,
   output logic                push,
   output wr_word_t            word,
   output logic                perr
);
   localparam int         LANES    = PORT_W / 8;
   localparam logic [1:0] STEP     = 2'(LANES % SYS_LANES);
   localparam logic [1:0] LAST_PTR = 2'(SYS_LANES - LANES);

   logic [SYS_W-1:0]     acc_data, nxt_data;
   logic [SYS_LANES-1:0] acc_be, nxt_be;
   logic [1:0]           ptr;
   logic [29:0]          waddr;
   logic [LANES-1:0]     gen_par;
   logic                 beat_ok, last;

   always_comb begin
      for (int i = 0; i < LANES; i++) gen_par[i] = ^beat_data[8*i +: 8];
   end

   assign beat_ok = !par_en || (gen_par == beat_par);
   assign last    = single || (ptr == LAST_PTR);

   // lay the beat into the lanes at ptr; enables only for a clean beat
   always_comb begin
      nxt_data = acc_data;
      nxt_be   = acc_be;
      for (int i = 0; i < LANES; i++) begin
         nxt_data[8*(int'(ptr)+i) +: 8] = beat_data[8*i +: 8];
         if (beat_ok) nxt_be[int'(ptr)+i] = 1'b1;
      end
   end

   assign push = beat && last && (nxt_be != '0);
   assign perr = beat && !beat_ok;
   assign word = '{waddr: waddr, be: nxt_be, data: nxt_data};

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_data <= '0;
         acc_be   <= '0;
         ptr      <= '0;
         waddr    <= '0;
      end else if (load) begin
         acc_data <= '0;
         acc_be   <= '0;
         ptr      <= load_ptr;
         waddr    <= load_waddr;
      end else if (beat) begin
         if (last) begin
            acc_be <= '0;
            ptr    <= '0;
            waddr  <= waddr + 1'b1;
         end else begin
            acc_data <= nxt_data;
            acc_be   <= nxt_be;
            ptr      <= ptr + STEP;
         end
      end
   end

endmodule

// File: rtl/pbb_sysport.sv
module pbb_sysport
   import pbb_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 par_en,
   input  logic                 wf_empty,
   input  wr_word_t             wf_head,
   output logic                 wf_pop,
   input  logic                 rd_want,
   input  logic [29:0]          rd_waddr,
   output logic                 rd_take,
   output logic                 rf_push,
   output logic [SYS_W-1:0]     rf_data,
   output logic                 rd_perr,
   output logic                 s_req,
   output logic                 s_we,
   output logic [31:0]          s_addr,
   output logic [SYS_LANES-1:0] s_be,
   output logic [SYS_W-1:0]     s_wdata,
   output logic [SYS_LANES-1:0] s_wpar,
   input  logic                 s_ack,
   input  logic [SYS_W-1:0]     s_rdata,
   input  logic [SYS_LANES-1:0] s_rpar
);
   logic busy;

   // queued writes always win, which keeps reads behind earlier writes
   assign wf_pop  = !busy && !wf_empty;
   assign rd_take = !busy && wf_empty && rd_want;
   assign rf_push = busy && !s_we && s_ack;
   assign rf_data = s_rdata;
   assign rd_perr = rf_push && par_en && (s_rpar != lane_parity(s_rdata));
   assign s_req   = busy;
   assign s_wpar  = lane_parity(s_wdata);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy    <= 1'b0;
         s_we    <= 1'b0;
         s_addr  <= '0;
         s_be    <= '0;
         s_wdata <= '0;
      end else if (!busy) begin
         if (wf_pop) begin
            busy    <= 1'b1;
            s_we    <= 1'b1;
            s_addr  <= {wf_head.waddr, 2'b00};
            s_be    <= wf_head.be;
            s_wdata <= wf_head.data;
         end else if (rd_take) begin
            busy    <= 1'b1;
            s_we    <= 1'b0;
            s_addr  <= {rd_waddr, 2'b00};
            s_be    <= '1;
            s_wdata <= '0;
         end
      end else if (s_ack) begin
         busy <= 1'b0;
      end
   end

endmodule

// File: rtl/proc_burst_bridge.sv
module proc_burst_bridge
   import pbb_pkg::*;
#(
   parameter int PORT_W     = 32,
   parameter int FIFO_DEPTH = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                par_en,
   input  logic                p_req,
   input  logic                p_wr,
   input  logic                p_burst,
   input  logic [31:0]         p_addr,
   input  logic [PORT_W-1:0]   p_wdata,
   input  logic [PORT_W/8-1:0] p_wpar,
   output logic                p_ack,
   output logic                p_err,
   output logic [PORT_W-1:0]   p_rdata,
   output logic [PORT_W/8-1:0] p_rpar,
   output logic                par_err,
   output logic                s_req,
   output logic                s_we,
   output logic [31:0]         s_addr,
   output logic [3:0]          s_be,
   output logic [31:0]         s_wdata,
   output logic [3:0]          s_wpar,
   input  logic                s_ack,
   input  logic [31:0]         s_rdata,
   input  logic [3:0]          s_rpar
);
   localparam int         LANES       = PORT_W / 8;
   localparam int         BURST_BEATS = LINE_BYTES / LANES;
   localparam logic [1:0] STEP        = 2'(LANES % SYS_LANES);
   localparam logic [1:0] LAST_PTR    = 2'(SYS_LANES - LANES);
   localparam logic [1:0] PTR_MASK    = ~2'(LANES - 1);
   localparam int         WW          = $bits(wr_word_t);

   if (!(PORT_W == 8 || PORT_W == 16 || PORT_W == 32)) begin : g_bad_port_w
      $error("proc_burst_bridge: PORT_W must be 8, 16 or 32");
   end
   if (FIFO_DEPTH < LINE_WORDS || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("proc_burst_bridge: FIFO_DEPTH must be a power of two of at least 4");
   end

   pbb_state_e       state;
   logic             cmd_wr, cmd_single;
   logic [4:0]       beats_left;
   logic [2:0]       rd_left;
   logic [29:0]      rd_waddr;
   logic [1:0]       rd_ptr, start_ptr;
   logic             rd_last, bad_burst, accept;

   wr_word_t         wf_in, wf_head;
   logic             wf_push, wf_pop, wf_full, wf_empty, wp_perr;
   logic [SYS_W-1:0] rf_in, rf_head;
   logic             rf_push, rf_pop, rf_full, rf_empty, rd_perr;
   logic             rd_want, rd_take;
   logic [WW-1:0]    wf_dout;

   assign bad_burst = p_burst && (p_addr[3:0] != 4'd0);
   assign accept    = (state == ST_IDLE) && p_req && !bad_burst;
   assign start_ptr = p_burst ? 2'b00 : (p_addr[1:0] & PTR_MASK);
   assign rd_last   = cmd_single || (rd_ptr == LAST_PTR);
   assign p_ack     = (state == ST_XFER) && (cmd_wr ? !wf_full : !rf_empty);
   assign p_err     = (state == ST_REJECT);
   assign rf_pop    = p_ack && !cmd_wr && rd_last;
   assign rd_want   = (rd_left != 3'd0) && !rf_full;
   assign wf_head   = wr_word_t'(wf_dout);

   // read beat selection: full-width port takes the word as is
   if (LANES == SYS_LANES) begin : g_rd_full
      assign p_rdata = rf_head;
   end else begin : g_rd_narrow
      assign p_rdata = rf_head[8*int'(rd_ptr) +: PORT_W];
   end

   for (genvar g = 0; g < LANES; g++) begin : g_rpar
      assign p_rpar[g] = ^p_rdata[8*g +: 8];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state      <= ST_IDLE;
         cmd_wr     <= 1'b0;
         cmd_single <= 1'b0;
         beats_left <= '0;
         rd_left    <= '0;
         rd_waddr   <= '0;
         rd_ptr     <= '0;
         par_err    <= 1'b0;
      end else begin
         if (wp_perr || rd_perr) par_err <= 1'b1;
         if (rd_take) begin
            rd_left  <= rd_left - 1'b1;
            rd_waddr <= rd_waddr + 1'b1;
         end
         case (state)
            ST_IDLE: begin
               if (p_req && bad_burst) begin
                  state <= ST_REJECT;
               end else if (accept) begin
                  state      <= ST_XFER;
                  cmd_wr     <= p_wr;
                  cmd_single <= !p_burst;
                  beats_left <= p_burst ? 5'(BURST_BEATS) : 5'd1;
                  rd_ptr     <= start_ptr;
                  if (!p_wr) begin
                     rd_left  <= p_burst ? 3'(LINE_WORDS) : 3'd1;
                     rd_waddr <= p_addr[31:2];
                  end
               end
            end
            ST_XFER: begin
               if (p_ack) begin
                  beats_left <= beats_left - 1'b1;
                  if (!cmd_wr) rd_ptr <= rd_last ? 2'b00 : rd_ptr + STEP;
                  if (beats_left == 5'd1) state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   pbb_wpack #(.PORT_W(PORT_W)) i_wpack (
      .clk        (clk),
      .rst        (rst),
      .par_en     (par_en),
      .load       (accept && p_wr),
      .load_ptr   (start_ptr),
      .load_waddr (p_addr[31:2]),
      .single     (cmd_single),
      .beat       (p_ack && cmd_wr),
      .beat_data  (p_wdata),
      .beat_par   (p_wpar),
      .push       (wf_push),
      .word       (wf_in),
      .perr       (wp_perr)
   );

   pbb_fifo #(.WIDTH(WW), .DEPTH(FIFO_DEPTH)) i_wfifo (
      .clk   (clk),
      .rst   (rst),
      .push  (wf_push),
      .pop   (wf_pop),
      .din   (wf_in),
      .dout  (wf_dout),
      .full  (wf_full),
      .empty (wf_empty)
   );

   pbb_fifo #(.WIDTH(SYS_W), .DEPTH(FIFO_DEPTH)) i_rfifo (
      .clk   (clk),
      .rst   (rst),
      .push  (rf_push),
      .pop   (rf_pop),
      .din   (rf_in),
      .dout  (rf_head),
      .full  (rf_full),
      .empty (rf_empty)
   );

   pbb_sysport i_sysport (
      .clk      (clk),
      .rst      (rst),
      .par_en   (par_en),
      .wf_empty (wf_empty),
      .wf_head  (wf_head),
      .wf_pop   (wf_pop),
      .rd_want  (rd_want),
      .rd_waddr (rd_waddr),
      .rd_take  (rd_take),
      .rf_push  (rf_push),
      .rf_data  (rf_in),
      .rd_perr  (rd_perr),
      .s_req    (s_req),
      .s_we     (s_we),
      .s_addr   (s_addr),
      .s_be     (s_be),
      .s_wdata  (s_wdata),
      .s_wpar   (s_wpar),
      .s_ack    (s_ack),
      .s_rdata  (s_rdata),
      .s_rpar   (s_rpar)
   );

endmodule

// File: rtl/proc_burst_bridge_chk.sv
module proc_burst_bridge_chk (
   input logic        clk,
   input logic        rst,
   input logic        p_req,
   input logic        p_burst,
   input logic [31:0] p_addr,
   input logic        p_ack,
   input logic        p_err,
   input logic        par_err,
   input logic        s_req,
   input logic        s_we,
   input logic [31:0] s_addr,
   input logic [3:0]  s_be,
   input logic [31:0] s_wdata,
   input logic        s_ack,
   input logic        wf_push,
   input logic        wf_full,
   input logic        rf_push,
   input logic        rf_full
);

   p_quiet_after_reset_r12: assert property (@(posedge clk)
      rst |=> (!p_ack && !p_err && !s_req && !par_err));

   p_sticky_error_r9: assert property (@(posedge clk) disable iff (rst)
      par_err |=> par_err);

   p_reject_cause_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(p_err) |-> $past(p_req && p_burst && (p_addr[3:0] != 4'd0)));

   p_reject_pulse_r5: assert property (@(posedge clk) disable iff (rst)
      p_err |=> !p_err);

   p_reject_no_ack_r5: assert property (@(posedge clk) disable iff (rst)
      p_err |-> !p_ack);

   p_hold_request_r10: assert property (@(posedge clk) disable iff (rst)
      (s_req && !s_ack) |=> (s_req && $stable(s_addr) && $stable(s_we)
                             && $stable(s_be) && $stable(s_wdata)));

   p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
      !(wf_push && wf_full) && !(rf_push && rf_full));

   p_write_enables_r7: assert property (@(posedge clk) disable iff (rst)
      (s_req && s_we) |-> (s_be != 4'd0));

endmodule

bind proc_burst_bridge proc_burst_bridge_chk i_chk (
   .clk     (clk),
   .rst     (rst),
   .p_req   (p_req),
   .p_burst (p_burst),
   .p_addr  (p_addr),
   .p_ack   (p_ack),
   .p_err   (p_err),
   .par_err (par_err),
   .s_req   (s_req),
   .s_we    (s_we),
   .s_addr  (s_addr),
   .s_be    (s_be),
   .s_wdata (s_wdata),
   .s_ack   (s_ack),
   .wf_push (wf_push),
   .wf_full (wf_full),
   .rf_push (rf_push),
   .rf_full (rf_full)
);

// File: tb/test_proc_burst_bridge.sv
`timescale 1ns/1ps
module test_proc_burst_bridge;
   localparam int PW = 16;
   localparam int LN = PW / 8;
   localparam int NB = 16 / LN;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          par_en = 1'b0;
   logic          p_req = 1'b0, p_wr = 1'b0, p_burst = 1'b0;
   logic [31:0]   p_addr = '0;
   logic [PW-1:0] p_wdata = '0;
   logic [LN-1:0] p_wpar = '0;
   logic          p_ack, p_err, par_err;
   logic [PW-1:0] p_rdata;
   logic [LN-1:0] p_rpar;
   logic          s_req, s_we;
   logic [31:0]   s_addr, s_wdata;
   logic [3:0]    s_be, s_wpar;
   logic          s_ack = 1'b0;
   logic [31:0]   s_rdata = '0;
   logic [3:0]    s_rpar = '0;

   int checks = 0, errors = 0;

   always #2 clk = ~clk;

   proc_burst_bridge #(.PORT_W(PW), .FIFO_DEPTH(4)) i_proc_burst_bridge (
      .clk(clk), .rst(rst), .par_en(par_en),
      .p_req(p_req), .p_wr(p_wr), .p_burst(p_burst), .p_addr(p_addr),
      .p_wdata(p_wdata), .p_wpar(p_wpar), .p_ack(p_ack), .p_err(p_err),
      .p_rdata(p_rdata), .p_rpar(p_rpar), .par_err(par_err),
      .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_be(s_be),
      .s_wdata(s_wdata), .s_wpar(s_wpar), .s_ack(s_ack),
      .s_rdata(s_rdata), .s_rpar(s_rpar));

   // ---------------- system-bus memory model ----------------
   logic [31:0] mem [64];
   logic [31:0] wl_addr [64];
   logic [31:0] wl_data [64];
   logic [3:0]  wl_be   [64];
   logic        wl_pok  [64];
   int          wcount = 0, rcount = 0, wait_cnt = 0, slv_delay = 0;
   logic        corrupt = 1'b0;

   function automatic logic [3:0] par32(input logic [31:0] d);
      for (int i = 0; i < 4; i++) par32[i] = ^d[8*i +: 8];
   endfunction

   function automatic logic [LN-1:0] parp(input logic [PW-1:0] d);
      for (int i = 0; i < LN; i++) parp[i] = ^d[8*i +: 8];
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         s_ack    <= 1'b0;
         wait_cnt <= 0;
      end else begin
         s_ack <= 1'b0;
         if (s_req && !s_ack) begin
            if (wait_cnt < slv_delay) wait_cnt <= wait_cnt + 1;
            else begin
               wait_cnt <= 0;
               s_ack    <= 1'b1;
               if (s_we) begin
                  for (int i = 0; i < 4; i++)
                     if (s_be[i]) mem[s_addr[7:2]][8*i +: 8] <= s_wdata[8*i +: 8];
                  if (wcount < 64) begin
                     wl_addr[wcount] <= s_addr;
                     wl_data[wcount] <= s_wdata;
                     wl_be[wcount]   <= s_be;
                     wl_pok[wcount]  <= (s_wpar == par32(s_wdata));
                  end
                  wcount <= wcount + 1;
               end else begin
                  s_rdata <= mem[s_addr[7:2]];
                  s_rpar  <= par32(mem[s_addr[7:2]]) ^ {3'b000, corrupt};
                  rcount  <= rcount + 1;
               end
            end
         end
      end
   end

   // ---------------- helpers ----------------
   logic [PW-1:0] beat_wd  [16];
   logic [LN-1:0] beat_bad [16];
   logic [PW-1:0] beat_rd  [16];
   logic [LN-1:0] beat_rp  [16];
   int            nacks, nstall;

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic settle();
      repeat (60) @(negedge clk);
   endtask

   task automatic fill(input logic [PW-1:0] seed);
      for (int b = 0; b < 16; b++) begin
         beat_wd[b]  = seed + PW'(b * 16'h0203);
         beat_bad[b] = '0;
      end
   endtask

   task automatic xfer(input logic wr, input logic burst, input logic [31:0] addr);
      int n = burst ? NB : 1;
      nacks = 0;
      nstall = 0;
      @(negedge clk);
      p_req = 1'b1; p_wr = wr; p_burst = burst; p_addr = addr;
      for (int b = 0; b < n; b++) begin
         p_wdata = beat_wd[b];
         p_wpar  = parp(beat_wd[b]) ^ beat_bad[b];
         while (!p_ack && nstall < 2000) begin
            @(negedge clk);
            nstall++;
         end
         if (p_ack) nacks++;
         beat_rd[b] = p_rdata;
         beat_rp[b] = p_rpar;
         @(negedge clk);
      end
      p_req = 1'b0;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset_state();
      do_reset();
      chk("R12", "ack after reset",     {31'd0, p_ack},   32'd0);
      chk("R12", "request after reset", {31'd0, s_req},   32'd0);
      chk("R12", "error after reset",   {31'd0, par_err}, 32'd0);
      chk("R12", "reject after reset",  {31'd0, p_err},   32'd0);
   endtask

   task automatic t_burst_write();
      int w0 = wcount;
      fill(16'h1020);
      xfer(1'b1, 1'b1, 32'h40);
      settle();
      chk("R1", "burst write beats", nacks, NB);
      chk("R2", "burst write count", wcount - w0, 4);
      for (int j = 0; j < 4; j++) begin
         chk("R2", "word address", wl_addr[w0+j], 32'h40 + 32'(4*j));
         chk("R2", "word data",    wl_data[w0+j], {beat_wd[2*j+1], beat_wd[2*j]});
         chk("R2", "word enables", {28'd0, wl_be[w0+j]}, 32'hF);
         chk("R6", "write parity", {31'd0, wl_pok[w0+j]}, 32'd1);
      end
   endtask

   task automatic t_single_write();
      int w0 = wcount;
      beat_wd[0] = 16'hBEEF; beat_bad[0] = '0;
      xfer(1'b1, 1'b0, 32'h52);
      settle();
      chk("R1", "single write beats", nacks, 1);
      chk("R3", "single write count", wcount - w0, 1);
      chk("R3", "single address", wl_addr[w0], 32'h50);
      chk("R3", "single enables", {28'd0, wl_be[w0]}, 32'hC);
      chk("R3", "single data lanes", {16'd0, wl_data[w0][31:16]}, 32'hBEEF);
   endtask

   task automatic t_reads();
      logic [31:0] w;
      xfer(1'b0, 1'b1, 32'h40);
      chk("R1", "burst read beats", nacks, NB);
      for (int b = 0; b < NB; b++) begin
         w = mem[16 + b/2];
         chk("R4", "burst read beat", {16'd0, beat_rd[b]}, {16'd0, w[16*(b%2) +: 16]});
         chk("R6", "read parity", {30'd0, beat_rp[b]}, {30'd0, parp(beat_rd[b])});
      end
      xfer(1'b0, 1'b0, 32'h52);
      chk("R4", "single read upper", {16'd0, beat_rd[0]}, 32'hBEEF);
      xfer(1'b0, 1'b0, 32'h50);
      chk("R4", "single read lower", {16'd0, beat_rd[0]}, 32'h0000);
   endtask

   task automatic t_unaligned();
      int w0 = wcount, r0 = rcount, acks = 0, errs = 0;
      @(negedge clk);
      p_req = 1'b1; p_wr = 1'b1; p_burst = 1'b1; p_addr = 32'h44;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         if (p_ack) acks++;
         if (p_err) begin
            errs++;
            p_req = 1'b0;
         end
      end
      p_req = 1'b0;
      settle();
      chk("R5", "reject pulses", errs, 1);
      chk("R5", "reject acks", acks, 0);
      chk("R5", "reject system traffic", (wcount - w0) + (rcount - r0), 0);
   endtask

   task automatic t_parity_write();
      int w0;
      par_en = 1'b0;
      w0 = wcount;
      fill(16'h3355);
      beat_bad[1] = 2'b01;
      xfer(1'b1, 1'b1, 32'h60);
      settle();
      chk("R7", "unchecked bad beat enables", {28'd0, wl_be[w0]}, 32'hF);
      chk("R7", "unchecked no error", {31'd0, par_err}, 32'd0);
      par_en = 1'b1;
      w0 = wcount;
      fill(16'h7711);
      beat_bad[3] = 2'b10;
      xfer(1'b1, 1'b1, 32'h60);
      settle();
      chk("R7", "checked write count", wcount - w0, 4);
      chk("R7", "bad beat lanes dropped", {28'd0, wl_be[w0+1]}, 32'h3);
      chk("R7", "good word enables", {28'd0, wl_be[w0+2]}, 32'hF);
      chk("R7", "error set", {31'd0, par_err}, 32'd1);
      w0 = wcount;
      beat_wd[0] = 16'h1234; beat_bad[0] = 2'b11;
      xfer(1'b1, 1'b0, 32'h64);
      settle();
      chk("R7", "fully bad single issues nothing", wcount - w0, 0);
      fill(16'h0101);
      xfer(1'b1, 1'b1, 32'h40);
      settle();
      chk("R9", "error stays set", {31'd0, par_err}, 32'd1);
      do_reset();
      chk("R9", "error cleared by reset", {31'd0, par_err}, 32'd0);
   endtask

   task automatic t_parity_read();
      logic [31:0] w = mem[16];
      par_en = 1'b0; corrupt = 1'b1;
      xfer(1'b0, 1'b0, 32'h40);
      chk("R8", "unchecked read parity ignored", {31'd0, par_err}, 32'd0);
      par_en = 1'b1;
      xfer(1'b0, 1'b0, 32'h40);
      chk("R8", "data still delivered", {16'd0, beat_rd[0]}, {16'd0, w[15:0]});
      chk("R8", "read parity error", {31'd0, par_err}, 32'd1);
      corrupt = 1'b0;
      do_reset();
   endtask

   task automatic t_backpressure();
      logic [PW-1:0] saved [32];
      int stalls;
      slv_delay = 12;
      fill(16'h4C00);
      for (int b = 0; b < 16; b++) saved[b] = beat_wd[b];
      xfer(1'b1, 1'b1, 32'h70);
      fill(16'h9A00);
      for (int b = 0; b < 16; b++) saved[16+b] = beat_wd[b];
      xfer(1'b1, 1'b1, 32'h80);
      stalls = nstall;
      chk("R10", "write stalled on full queue", {31'd0, stalls > 0}, 32'd1);
      chk("R10", "all beats still taken", nacks, NB);
      xfer(1'b0, 1'b1, 32'h70);
      for (int b = 0; b < NB; b++)
         chk("R11", "read sees earlier write", {16'd0, beat_rd[b]}, {16'd0, saved[b]});
      xfer(1'b0, 1'b1, 32'h80);
      for (int b = 0; b < NB; b++)
         chk("R11", "second line read back", {16'd0, beat_rd[b]}, {16'd0, saved[16+b]});
      slv_delay = 0;
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = '0;
      t_reset_state();
      t_burst_write();
      t_single_write();
      t_reads();
      t_unaligned();
      t_parity_write();
      t_parity_read();
      t_backpressure();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule